// File: doc/BRIEF.md
# Fast Ethernet PCS Receive Decoder

This block sits between the clock-recovery front end of a 100 Mb/s Ethernet receiver and the MAC. Each cycle of the recovered bit clock it takes one line symbol. In copper mode the symbol is a three-level MLT3 value. In fiber mode it is an NRZI bit. The block turns the line symbols back into plain NRZ data. In copper mode it then removes the 11-bit scrambler sequence. It finds the 5-bit code-group boundary from the start-of-stream delimiter, and delivers one decoded 4-bit nibble per code group with frame-valid and error flags.

The descrambler synchronises itself. While the line carries idle it assumes the plain data are all ones and loads its key register from the received bits. It declares lock once enough consecutive descrambled ones have been seen. Frames are searched for only after lock. In fiber mode the MLT3 stage and the descrambler are both bypassed, and the block counts as locked at once. The mode pin must stay constant between resets.

Top module: `fe_pcs_rx`

## Requirements
- R1: After a reset in copper mode, `rx_stb`, `rx_dv`, `rx_er` and `locked` are all low.
- R2: In copper mode a change of line level between successive symbols is an NRZI transition. Any NRZI transition decodes to an NRZ one, and no transition decodes to a zero. The symbol encoding is 2'b00 zero, 2'b01 positive, 2'b11 negative.
- R3: In copper mode the descrambler recovers the key stream k(t) = k(t-11) XOR k(t-9) from idle, which is plain all ones. It raises `locked` after 30 consecutive descrambled ones. `locked` then stays high until reset.
- R4: In fiber mode `line_bit` is taken directly as NRZI and no descrambling is applied. `locked` reads high from the second cycle after reset.
- R5: While `locked` is low, a start delimiter is ignored: `rx_dv` stays low and `rx_stb` never pulses.
- R6: When the 10 descrambled bits 1100010001 (first received leftmost) arrive while locked, the code-group boundary is set. `rx_dv` rises with one `rx_stb` carrying `rxd` = 4'b0101.
- R7: Inside a frame, every 5 bits form one code group, sent first bit as MSB. A data group gives one `rx_stb` with `rxd` set to its nibble: 0=11110 1=01001 2=10100 3=10101 4=01010 5=01011 6=01110 7=01111 8=10010 9=10011 A=10110 B=10111 C=11010 D=11011 E=11100 F=11101.
- R8: The end group 01101 clears `rx_dv` without a strobe. The R group 00111 that follows it starts no new frame.
- R9: Any other 5-bit group inside a frame, except idle, gives one `rx_stb` with `rx_er` high. The frame continues.
- R10: An idle group 11111 inside a frame gives one `rx_stb` with `rx_er` high and clears `rx_dv` in the same cycle.
- R11: `rx_stb` never stays high in two consecutive cycles, and `rx_er` is high only together with `rx_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fiber_mode | input | 1 | 1: NRZI line bit, no descrambling; 0: MLT3 copper |
| line_sym | input | 2 | MLT3 level, copper mode |
| line_bit | input | 1 | NRZI bit, fiber mode |
| rxd | output | 4 | Decoded nibble, valid with `rx_stb` |
| rx_stb | output | 1 | One-cycle pulse per delivered nibble |
| rx_dv | output | 1 | Frame in progress |
| rx_er | output | 1 | Code-group error, valid with `rx_stb` |
| locked | output | 1 | Descrambler synchronised |

## Verification
A transmit model in the bench scrambles, NRZI-codes and MLT3-codes the traffic. In copper mode a frame carrying all sixteen nibble values shows that level-change decoding, descrambling and the full code table all hold together. The fiber frame uses the same delimiters with a different payload, which separates the bypass path from the scrambled path. A start delimiter sent before lock tells search gating apart from plain delimiter detection. Frames holding a stray group or a premature idle show the two error endings apart: one keeps the frame open and the other closes it.

// File: rtl/fe_pcs_pkg.sv
// Shared code-group constants and the 5-bit to nibble decoder.
// Assumes code groups are written with the first received bit as MSB.
package fe_pcs_pkg;

    localparam int GRP_W = 5;
    localparam int NIB_W = 4;
    localparam int PAIR_W = 2 * GRP_W;

    localparam logic [PAIR_W-1:0] SSD_PAIR  = 10'b11000_10001;
    localparam logic [GRP_W-1:0]  CG_END    = 5'b01101;
    localparam logic [GRP_W-1:0]  CG_IDLE   = 5'b11111;
    localparam logic [NIB_W-1:0]  PRE_NIB   = 4'b0101;

    typedef enum logic [1:0] {
        K_DATA,
        K_END,
        K_IDLE,
        K_BAD
    } cg_kind_e;

    typedef struct packed {
        cg_kind_e           kind;
        logic [NIB_W-1:0]   nib;
    } cg_dec_t;

    // Classify one code group and return its nibble when it is data.
    function automatic cg_dec_t cg_decode(input logic [GRP_W-1:0] cg);
        cg_dec_t r;
        r.kind = K_DATA;
        r.nib  = '0;
        case (cg)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            CG_END:   r.kind = K_END;
            CG_IDLE:  r.kind = K_IDLE;
            default:  r.kind = K_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fe_line_dec.sv
// Line decoder: turns MLT3 levels (copper) or NRZI bits (fiber) into NRZ.
// Assumes symbols are already sampled on the recovered clock; two cycles latency.
module fe_line_dec #(
    parameter int SYM_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fiber_mode,
    input  logic [SYM_W-1:0] line_sym,
    input  logic             line_bit,
    output logic             nrz_out
);

    logic [SYM_W-1:0] sym_prev;
    logic             nrzi_q;
    logic             nrzi_d;

    // Rebuild the NRZI waveform: toggle on every MLT3 level change, or take the fiber bit.
    always_ff @(posedge clk) begin
        sym_prev <= line_sym;
        if (!rst_n) begin
            nrzi_q <= 1'b0;
        end else if (fiber_mode) begin
            nrzi_q <= line_bit;
        end else begin
            nrzi_q <= nrzi_q ^ (line_sym != sym_prev);
        end
    end

    // NRZI to NRZ: a one wherever the NRZI level moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nrzi_d  <= 1'b0;
            nrz_out <= 1'b0;
        end else begin
            nrzi_d  <= nrzi_q;
            nrz_out <= nrzi_q ^ nrzi_d;
        end
    end

    // R2: a flat MLT3 level leaves the NRZI level unchanged.
    a_r2_flat_level_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!fiber_mode && line_sym == $past(line_sym)) |=> $stable(nrzi_q));

    // R4: in fiber mode the line bit is the NRZI level.
    a_r4_fiber_line_is_nrzi: assert property (@(posedge clk) disable iff (!rst_n)
        fiber_mode |=> (nrzi_q == $past(line_bit)));

endmodule

// File: rtl/fe_descrambler.sv
// Self-synchronising descrambler for the 11-bit key sequence.
// Assumes plain idle is all ones; loads its key register from the line until lock.
module fe_descrambler #(
    parameter int LFSR_W   = 11,
    parameter int TAP_HI   = 10,
    parameter int TAP_LO   = 8,
    parameter int LOCK_RUN = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fiber_mode,
    input  logic nrz_in,
    output logic plain_out,
    output logic locked
);

    localparam int RUN_W = $clog2(LOCK_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

    logic [LFSR_W-1:0] key_sr;
    logic [RUN_W-1:0]  run;
    logic              key_bit;
    logic              plain_bit;

    // Predicted key bit and the descrambled bit it yields.
    always_comb begin
        key_bit   = key_sr[TAP_HI] ^ key_sr[TAP_LO];
        plain_bit = nrz_in ^ key_bit;
    end

    // Track the key stream: load from the line while hunting, free-run once locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_sr    <= '0;
            run       <= '0;
            locked    <= 1'b0;
            plain_out <= 1'b0;
        end else if (fiber_mode) begin
            plain_out <= nrz_in;
            locked    <= 1'b1;
        end else if (locked) begin
            key_sr    <= {key_sr[LFSR_W-2:0], key_bit};
            plain_out <= plain_bit;
        end else begin
            key_sr    <= {key_sr[LFSR_W-2:0], ~nrz_in};
            plain_out <= plain_bit;
            if (plain_bit) begin
                run <= run + 1'b1;
                if (run >= RUN_LAST) begin
                    locked <= 1'b1;
                end
            end else begin
                run <= '0;
            end
        end
    end

    // R3: lock, once gained, holds until reset.
    a_r3_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R4: fiber mode passes the NRZ bit through untouched and reads locked.
    a_r4_fiber_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        fiber_mode |=> (plain_out == $past(nrz_in)) && locked);

endmodule

// File: rtl/fe_cg_align.sv
// Code-group aligner and decoder: finds the start delimiter pair, then slices
// five bits per group and emits one nibble strobe per group.
// Assumes one plain bit per cycle and a lock flag aligned with that bit.
module fe_cg_align
    import fe_pcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             locked_in,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_stb,
    output logic             rx_dv,
    output logic             rx_er
);

    localparam int CNT_W = $clog2(GRP_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GRP_W - 1);

    logic [PAIR_W-1:0] win_q;
    logic [PAIR_W-1:0] win_n;
    logic [CNT_W-1:0]  cnt;
    logic              in_frame;
    cg_dec_t           dec;

    // Window including the newest bit, and the decode of its last group.
    always_comb begin
        win_n = {win_q[PAIR_W-2:0], bit_in};
        dec   = cg_decode(win_n[GRP_W-1:0]);
    end

    // Search for the delimiter pair, then decode each completed group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q    <= '0;
            cnt      <= '0;
            in_frame <= 1'b0;
            rxd      <= '0;
            rx_stb   <= 1'b0;
            rx_dv    <= 1'b0;
            rx_er    <= 1'b0;
        end else begin
            win_q  <= win_n;
            rx_stb <= 1'b0;
            rx_er  <= 1'b0;
            if (!in_frame) begin
                if (locked_in && win_n == SSD_PAIR) begin
                    in_frame <= 1'b1;
                    cnt      <= '0;
                    rx_dv    <= 1'b1;
                    rx_stb   <= 1'b1;
                    rxd      <= PRE_NIB;
                end
            end else if (cnt == CNT_LAST) begin
                cnt <= '0;
                case (dec.kind)
                    K_DATA: begin
                        rx_stb <= 1'b1;
                        rxd    <= dec.nib;
                    end
                    K_END: begin
                        in_frame <= 1'b0;
                        rx_dv    <= 1'b0;
                    end
                    K_IDLE: begin
                        in_frame <= 1'b0;
                        rx_dv    <= 1'b0;
                        rx_stb   <= 1'b1;
                        rx_er    <= 1'b1;
                    end
                    default: begin
                        rx_stb <= 1'b1;
                        rx_er  <= 1'b1;
                    end
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R5: a frame can only open after the descrambler reported lock.
    a_r5_dv_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> $past(locked_in));

    // R6: a frame opens with a preamble nibble strobe.
    a_r6_open_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv) |-> rx_stb && (rxd == PRE_NIB) && !rx_er);

    // R8/R10: a frame closes either silently or on an error strobe.
    a_r10_close_kind: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_dv) |-> (!rx_stb || rx_er));

    // R11: strobes are never back to back.
    a_r11_stb_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |=> !rx_stb);

    // R11: the error flag only accompanies a strobe.
    a_r11_er_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er |-> rx_stb);

endmodule

// File: rtl/fe_pcs_rx.sv
// Fast Ethernet PCS receive path: line decode, descramble, align and decode.
// Assumes fiber_mode is held constant between resets.
module fe_pcs_rx
    import fe_pcs_pkg::*;
#(
    parameter int LOCK_RUN = 30,
    parameter int LFSR_W   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fiber_mode,
    input  logic [1:0]       line_sym,
    input  logic             line_bit,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_stb,
    output logic             rx_dv,
    output logic             rx_er,
    output logic             locked
);

    logic nrz_bit;
    logic plain_bit;

    fe_line_dec #(
        .SYM_W (2)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .fiber_mode (fiber_mode),
        .line_sym   (line_sym),
        .line_bit   (line_bit),
        .nrz_out    (nrz_bit)
    );

    fe_descrambler #(
        .LFSR_W   (LFSR_W),
        .TAP_HI   (LFSR_W - 1),
        .TAP_LO   (LFSR_W - 3),
        .LOCK_RUN (LOCK_RUN)
    ) u_dscr (
        .clk        (clk),
        .rst_n      (rst_n),
        .fiber_mode (fiber_mode),
        .nrz_in     (nrz_bit),
        .plain_out  (plain_bit),
        .locked     (locked)
    );

    fe_cg_align u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (plain_bit),
        .locked_in (locked),
        .rxd       (rxd),
        .rx_stb    (rx_stb),
        .rx_dv     (rx_dv),
        .rx_er     (rx_er)
    );

endmodule

// File: tb/fe_pcs_rx_test.sv
module fe_pcs_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fiber_mode = 1'b0;
    logic [1:0] line_sym = 2'b00;
    logic       line_bit = 1'b0;
    logic [3:0] rxd;
    logic       rx_stb;
    logic       rx_dv;
    logic       rx_er;
    logic       locked;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // transmit model state
    logic [10:0] scr = 11'h5A3;
    int          mlt_idx = 0;
    logic        nrzi_lvl = 1'b0;

    // monitor
    logic [3:0] got_d [0:1023];
    logic       got_e [0:1023];
    logic       got_v [0:1023];
    int         ns = 0;
    int         dv_rises = 0;
    int         r11_viol = 0;
    logic       prev_stb = 1'b0;
    logic       prev_dv = 1'b0;

    always #10 clk = ~clk;

    fe_pcs_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fiber_mode (fiber_mode),
        .line_sym   (line_sym),
        .line_bit   (line_bit),
        .rxd        (rxd),
        .rx_stb     (rx_stb),
        .rx_dv      (rx_dv),
        .rx_er      (rx_er),
        .locked     (locked)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_stb) begin
                got_d[ns % 1024] = rxd;
                got_e[ns % 1024] = rx_er;
                got_v[ns % 1024] = rx_dv;
                ns++;
            end
            if ((prev_stb && rx_stb) || (rx_er && !rx_stb)) r11_viol++;
            if (rx_dv && !prev_dv) dv_rises++;
            prev_stb = rx_stb;
            prev_dv  = rx_dv;
        end else begin
            prev_stb = 1'b0;
            prev_dv  = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    task automatic send_bit(input logic b);
        logic k;
        logic sb;
        @(negedge clk);
        if (!fiber_mode) begin
            k   = scr[10] ^ scr[8];
            scr = {scr[9:0], k};
            sb  = b ^ k;
        end else begin
            sb = b;
        end
        if (sb) begin
            nrzi_lvl = ~nrzi_lvl;
            mlt_idx  = (mlt_idx + 1) % 4;
        end
        line_bit = nrzi_lvl;
        line_sym = (mlt_idx == 1) ? 2'b01 : (mlt_idx == 3) ? 2'b11 : 2'b00;
    endtask

    task automatic send_code(input logic [4:0] c);
        for (int i = 4; i >= 0; i--) send_bit(c[i]);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_code(5'b11111);
    endtask

    task automatic send_jk();
        send_code(5'b11000);
        send_code(5'b10001);
    endtask

    task automatic send_tr();
        send_code(5'b01101);
        send_code(5'b00111);
    endtask

    task automatic do_reset(input logic fib);
        @(negedge clk);
        rst_n = 1'b0;
        fiber_mode = fib;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1: outputs quiet after a copper reset
    task automatic t_reset();
        do_reset(1'b0);
        @(negedge clk);
        chk(rx_stb == 0 && rx_dv == 0 && rx_er == 0, "R1 outputs idle", {rx_stb, rx_dv, rx_er}, 0);
        chk(locked == 0, "R1 locked low", locked, 0);
    endtask

    // R5 then R3: delimiter before lock ignored, later lock acquired
    task automatic t_unlocked();
        int base;
        int rises;
        base  = ns;
        rises = dv_rises;
        send_idle(2);
        send_jk();
        send_code(enc(4'h1));
        send_code(enc(4'h2));
        send_tr();
        send_code(5'b11111);
        chk(ns == base, "R5 no strobe before lock", ns - base, 0);
        chk(dv_rises == rises, "R5 no rx_dv before lock", dv_rises - rises, 0);
        send_idle(40);
        chk(locked == 1, "R3 lock after idle", locked, 1);
    endtask

    // R2 R6 R7 R8: copper frame with every nibble value
    task automatic t_copper_frame();
        int base;
        base = ns;
        send_jk();
        for (int v = 0; v < 16; v++) send_code(enc(4'(v)));
        send_tr();
        send_idle(6);
        chk(ns - base == 17, "R8 strobe count copper", ns - base, 17);
        chk(got_d[base % 1024] == 4'h5 && got_v[base % 1024], "R6 preamble nibble", got_d[base % 1024], 5);
        for (int v = 0; v < 16; v++) begin
            chk(got_d[(base + 1 + v) % 1024] == 4'(v) && !got_e[(base + 1 + v) % 1024],
                "R7 R2 copper nibble", got_d[(base + 1 + v) % 1024], v);
        end
        chk(rx_dv == 0, "R8 rx_dv low after end", rx_dv, 0);
        chk(locked == 1, "R3 lock held", locked, 1);
    endtask

    // R9: stray group keeps the frame open
    task automatic t_bad_group();
        int base;
        base = ns;
        send_jk();
        send_code(enc(4'h1));
        send_code(5'b00000);
        send_code(enc(4'h2));
        chk(rx_dv == 1, "R9 frame stays open", rx_dv, 1);
        send_tr();
        send_idle(6);
        chk(ns - base == 4, "R9 strobe count", ns - base, 4);
        chk(got_e[(base + 2) % 1024] == 1 && got_v[(base + 2) % 1024] == 1, "R9 error strobe", got_e[(base + 2) % 1024], 1);
        chk(got_d[(base + 3) % 1024] == 4'h2 && !got_e[(base + 3) % 1024], "R9 data after error", got_d[(base + 3) % 1024], 2);
    endtask

    // R10: premature idle ends frame with error
    task automatic t_early_idle();
        int base;
        base = ns;
        send_jk();
        send_code(enc(4'h3));
        send_idle(8);
        chk(ns - base == 3, "R10 strobe count", ns - base, 3);
        chk(got_e[(base + 2) % 1024] == 1 && got_v[(base + 2) % 1024] == 0, "R10 error and dv cleared",
            {got_e[(base + 2) % 1024], got_v[(base + 2) % 1024]}, 2);
        chk(rx_dv == 0, "R10 rx_dv low", rx_dv, 0);
    endtask

    // R4: fiber bypass path
    task automatic t_fiber();
        int base;
        logic [3:0] pay [0:5];
        pay = '{4'h3, 4'hA, 4'hC, 4'h7, 4'h0, 4'hE};
        do_reset(1'b1);
        repeat (2) @(negedge clk);
        chk(locked == 1, "R4 fiber locked", locked, 1);
        send_idle(4);
        base = ns;
        send_jk();
        for (int i = 0; i < 6; i++) send_code(enc(pay[i]));
        send_tr();
        send_idle(6);
        chk(ns - base == 7, "R4 fiber strobe count", ns - base, 7);
        for (int i = 0; i < 6; i++) begin
            chk(got_d[(base + 1 + i) % 1024] == pay[i], "R4 fiber nibble", got_d[(base + 1 + i) % 1024], pay[i]);
        end
    endtask

    initial begin
        t_reset();
        t_unlocked();
        t_copper_frame();
        t_bad_group();
        t_early_idle();
        t_fiber();
        chk(r11_viol == 0, "R11 strobe spacing and error flag", r11_viol, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule